// File: doc/BRIEF.md
# Iterative Integer Divider

This block divides one 32-bit integer by another over several clock cycles. It handles all four division flavours of a 32-bit integer instruction set that has a multiply/divide extension: signed quotient, unsigned quotient, signed remainder and unsigned remainder. It sits beside the main pipeline. The pipeline raises `start_i` with both operands and an operation code, stalls while `busy_o` is high, and takes `result_o` when `done_o` pulses.

Internally, the divisor is first aligned to the dividend in a single step. The shift amount is the difference of the operands' leading-zero counts. The engine then walks the shifted divisor back down one bit position per cycle. At each position it compares the divisor with the running partial remainder. When the divisor fits, it subtracts it and sets the quotient bit for that position. Signed operands are reduced to magnitudes on entry, and the signs are restored on the final cycle. Division by zero and the single signed overflow case skip the iteration and return the architecturally defined values.

Top module: `int_divider`

## Requirements
- R1: `op_i` bit 1 selects the result (0 = quotient, 1 = remainder) and bit 0 selects signedness (0 = signed, 1 = unsigned). For unsigned operations the result is the unsigned quotient or remainder of the two 32-bit operands.
- R2: A signed quotient is truncated toward zero. Its sign is the exclusive-or of the operand signs.
- R3: A signed remainder has the sign of the dividend and satisfies dividend = quotient × divisor + remainder.
- R4: With a zero divisor, the quotient is all ones and the remainder equals the dividend, for both signed and unsigned operations.
- R5: For signed operations with dividend 0x80000000 and divisor 0xFFFFFFFF, the quotient is 0x80000000 and the remainder is 0.
- R6: `busy_o` stays high for between 2 and 34 consecutive cycles per operation, and `done_o` rises in its last busy cycle. The special cases of R4 and R5 take exactly 2 cycles, and an unsigned 0xFFFFFFFF / 1 takes 34.
- R7: `done_o` is high for exactly one cycle. `result_o` then holds its value until the next operation completes.
- R8: `start_i` is ignored while `busy_o` is high, including the cycle in which `done_o` is high. A running operation keeps its original operands.
- R9: A `start_i` sampled while idle makes `busy_o` high from the next cycle.
- R10: After reset, `busy_o`, `done_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a division (sampled only when idle) |
| op_i | input | 2 | Bit 1: remainder select, bit 0: unsigned select |
| dividend_i | input | 32 | Dividend operand |
| divisor_i | input | 32 | Divisor operand |
| busy_o | output | 1 | Operation in progress (pipeline stall) |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Quotient or remainder, held after done |

## Verification
The assertions check the handshake on every cycle:
- a start taken while idle always leads to busy;
- busy lasts until done, and done is a single pulse that ends busy;
- no run exceeds 34 cycles or is shorter than 2;
- the zero-divisor and signed-overflow results match the operands captured at start.

Only the bench scenarios can show that ordinary quotients and remainders are numerically right, with signs fixed up correctly, across many operand patterns. The same holds for the exact latencies at the extremes and for a result being held while a mid-run start is ignored.

// File: rtl/intdiv_pkg.sv
// Package intdiv_pkg
// Shared types and constants for the iterative divider.
// Assumes: op code bit 1 = remainder select, bit 0 = unsigned select.
package intdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_STEP  = 2'd2,
        ST_DONE  = 2'd3
    } div_state_e;

    localparam int OP_REM_BIT = 1;
    localparam int OP_UNS_BIT = 0;

endpackage

// File: rtl/div_lzc.sv
// Module div_lzc
// Counts leading zeros of a W-bit value; an all-zero input yields W.
// Assumes CW is wide enough to hold the value W.
module div_lzc #(
    parameter int W  = 32,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  val_i,
    output logic [CW-1:0] lz_o
);

    // Priority scan: the highest set bit, visited last, wins.
    always_comb begin
        lz_o = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (val_i[i]) lz_o = CW'(W - 1 - i);
        end
    end

endmodule

// File: rtl/div_step.sv
// Module div_step
// One compare-and-subtract step of the restoring divider.
// Assumes both inputs are unsigned magnitudes.
module div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] part_i,
    input  logic [W-1:0] dsr_i,
    output logic         fit_o,
    output logic [W-1:0] part_o
);

    // Subtract the divisor when it fits, otherwise pass the partial remainder through.
    always_comb begin
        fit_o  = (dsr_i <= part_i);
        part_o = fit_o ? (part_i - dsr_i) : part_i;
    end

endmodule

// File: rtl/div_sign_fix.sv
// Module div_sign_fix
// Restores the sign of the magnitude quotient or remainder and selects the result.
// Assumes the magnitudes come from the unsigned iteration.
module div_sign_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] rem_i,
    input  logic         neg_quo_i,
    input  logic         neg_rem_i,
    input  logic         sel_rem_i,
    output logic [W-1:0] res_o
);

    // Two's-complement negate the selected magnitude when its sign is negative.
    always_comb begin
        if (sel_rem_i) res_o = neg_rem_i ? (~rem_i + 1'b1) : rem_i;
        else           res_o = neg_quo_i ? (~quo_i + 1'b1) : quo_i;
    end

endmodule

// File: rtl/int_divider.sv
// Module int_divider
// Multi-cycle signed/unsigned integer divider with a start/busy/done handshake.
// Flow: IDLE captures magnitudes; ALIGN shifts the divisor by the leading-zero
// difference (or resolves special cases); STEP does one compare-subtract per
// bit position; DONE presents the sign-corrected result for one cycle.
// Assumes: start is ignored unless idle; the result is held until the next done.
module int_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] result_o
);
    import intdiv_pkg::*;

    localparam int          CW      = $clog2(W) + 1;
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    div_state_e   state_q;
    logic [W-1:0] mag_a_q, mag_b_q, raw_a_q;
    logic         neg_quo_q, neg_rem_q, sel_rem_q, div0_q, ovf_q;
    logic [W-1:0] part_q, dsr_q, quo_q, result_q;
    logic [CW-1:0] cnt_q;

    logic         uns_in, sa_in, sb_in;
    logic [CW-1:0] lz_a, lz_b, shamt;
    logic         fit;
    logic [W-1:0] part_nx, quo_nx, fixed_res, special_res;

    // Operand decode at the request boundary.
    always_comb begin
        uns_in = op_i[OP_UNS_BIT];
        sa_in  = !uns_in && dividend_i[W-1];
        sb_in  = !uns_in && divisor_i[W-1];
    end

    div_lzc #(.W(W), .CW(CW)) u_lz_a (.val_i(mag_a_q), .lz_o(lz_a));
    div_lzc #(.W(W), .CW(CW)) u_lz_b (.val_i(mag_b_q), .lz_o(lz_b));

    // Alignment distance; zero when the divisor already exceeds the dividend.
    always_comb shamt = (lz_b > lz_a) ? (lz_b - lz_a) : '0;

    div_step #(.W(W)) u_step (
        .part_i (part_q),
        .dsr_i  (dsr_q),
        .fit_o  (fit),
        .part_o (part_nx)
    );

    // Quotient collects one bit per step, most significant first.
    always_comb quo_nx = {quo_q[W-2:0], fit};

    div_sign_fix #(.W(W)) u_fix (
        .quo_i     (quo_nx),
        .rem_i     (part_nx),
        .neg_quo_i (neg_quo_q),
        .neg_rem_i (neg_rem_q),
        .sel_rem_i (sel_rem_q),
        .res_o     (fixed_res)
    );

    // Architecturally defined results for zero divisor and signed overflow.
    always_comb begin
        if (div0_q) special_res = sel_rem_q ? raw_a_q : '1;
        else        special_res = sel_rem_q ? '0 : raw_a_q;
    end

    // Sequencer and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mag_a_q   <= '0;
            mag_b_q   <= '0;
            raw_a_q   <= '0;
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
            sel_rem_q <= 1'b0;
            div0_q    <= 1'b0;
            ovf_q     <= 1'b0;
            part_q    <= '0;
            dsr_q     <= '0;
            quo_q     <= '0;
            cnt_q     <= '0;
            result_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        mag_a_q   <= sa_in ? (~dividend_i + 1'b1) : dividend_i;
                        mag_b_q   <= sb_in ? (~divisor_i + 1'b1) : divisor_i;
                        raw_a_q   <= dividend_i;
                        neg_quo_q <= sa_in ^ sb_in;
                        neg_rem_q <= sa_in;
                        sel_rem_q <= op_i[OP_REM_BIT];
                        div0_q    <= (divisor_i == '0);
                        ovf_q     <= !uns_in && (dividend_i == MOST_NEG) && (divisor_i == '1);
                        state_q   <= ST_ALIGN;
                    end
                end
                ST_ALIGN: begin
                    if (div0_q || ovf_q) begin
                        result_q <= special_res;
                        state_q  <= ST_DONE;
                    end else begin
                        part_q  <= mag_a_q;
                        dsr_q   <= mag_b_q << shamt;
                        quo_q   <= '0;
                        cnt_q   <= shamt;
                        state_q <= ST_STEP;
                    end
                end
                ST_STEP: begin
                    part_q <= part_nx;
                    quo_q  <= quo_nx;
                    dsr_q  <= dsr_q >> 1;
                    cnt_q  <= cnt_q - 1'b1;
                    if (cnt_q == '0) begin
                        result_q <= fixed_res;
                        state_q  <= ST_DONE;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = (state_q == ST_DONE);
    assign result_o = result_q;

endmodule

// File: rtl/int_divider_chk.sv
// Module int_divider_chk
// Protocol and special-case checker attached to int_divider by bind.
// Assumes it observes only the divider's ports.
module int_divider_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [1:0]   op_i,
    input logic [W-1:0] dividend_i,
    input logic [W-1:0] divisor_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] result_o
);
    localparam int MAXLAT = W + 2;
    localparam int LCW    = $clog2(MAXLAT) + 1;

    logic [LCW-1:0] bcnt;
    logic           cap_div0, cap_ovf, cap_rem;
    logic [W-1:0]   cap_dvd;

    // Busy-cycle counter for the latency window.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_o) bcnt <= '0;
        else                   bcnt <= bcnt + 1'b1;
    end

    // Capture the special-case conditions of each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_div0 <= 1'b0;
            cap_ovf  <= 1'b0;
            cap_rem  <= 1'b0;
            cap_dvd  <= '0;
        end else if (!busy_o && start_i) begin
            cap_div0 <= (divisor_i == '0);
            cap_ovf  <= !op_i[0] && (dividend_i == {1'b1, {(W-1){1'b0}}}) && (divisor_i == '1);
            cap_rem  <= op_i[1];
            cap_dvd  <= dividend_i;
        end
    end

    a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    a_r6_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    a_r6_max_latency: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (bcnt < LCW'(MAXLAT)));

    a_r6_min_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (bcnt >= LCW'(1)));

    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |-> $stable(result_o));

    a_r4_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_div0) |-> (result_o == (cap_rem ? cap_dvd : {W{1'b1}})));

    a_r5_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_ovf) |-> (result_o == (cap_rem ? {W{1'b0}} : cap_dvd)));

endmodule

bind int_divider int_divider_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .op_i       (op_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o)
);

// File: tb/int_divider_tb.sv
// Directed bench for int_divider: one task per scenario, each checking its own results.
module int_divider_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [1:0]   op_i = 2'b00;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] result_o;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [31:0] seed = 32'h1234_5678;

    int_divider #(.W(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .op_i       (op_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .result_o   (result_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: counts a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec = n_vec + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference from the requirements (R1..R5).
    function automatic logic [W-1:0] ref_div(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        if (b == '0) return op[1] ? a : '1;
        if (op[0]) return op[1] ? (a % b) : (a / b);
        if (a == 32'h8000_0000 && b == '1) return op[1] ? '0 : a;
        return op[1] ? W'($signed(a) % $signed(b)) : W'($signed(a) / $signed(b));
    endfunction

    // Issue one operation; returns the result and the number of busy cycles.
    task automatic run(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] res, output int lat);
        @(negedge clk);
        op_i = op; dividend_i = a; divisor_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        res = '0;
        for (int i = 0; i < 40; i++) begin
            if (busy_o) lat = lat + 1;
            if (done_o) begin
                res = result_o;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_op(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        logic [W-1:0] res;
        int lat;
        run(op, a, b, res, lat);
        chk(res == ref_div(op, a, b), req, res, ref_div(op, a, b));
        chk(lat >= 2 && lat <= 34, "R6 latency window", W'(lat), 32'd34);
    endtask

    task automatic t_reset;
        chk(!busy_o && !done_o && result_o == '0, "R10 reset state",
            {busy_o, done_o, result_o[29:0]}, '0);
    endtask

    task automatic t_unsigned;
        check_op(2'b01, 32'd100, 32'd7, "R1 DIVU small");
        check_op(2'b01, 32'hFFFF_FFFF, 32'd3, "R1 DIVU large");
        check_op(2'b11, 32'hDEAD_BEEF, 32'h0001_0000, "R1 REMU");
        check_op(2'b01, 32'd5, 32'd9, "R1 DIVU divisor above dividend");
        check_op(2'b01, 32'h8000_0000, 32'hFFFF_FFFF, "R1 DIVU no overflow special");
    endtask

    task automatic t_signed;
        check_op(2'b00, -32'sd100, 32'sd7, "R2 DIV neg/pos");
        check_op(2'b00, 32'sd100, -32'sd7, "R2 DIV pos/neg");
        check_op(2'b00, -32'sd100, -32'sd7, "R2 DIV neg/neg");
        check_op(2'b00, -32'sd3, 32'sd5, "R2 DIV truncates to zero");
    endtask

    task automatic t_rem;
        check_op(2'b10, -32'sd100, 32'sd7, "R3 REM neg dividend");
        check_op(2'b10, 32'sd100, -32'sd7, "R3 REM pos dividend");
        check_op(2'b10, -32'sd2147483647, -32'sd2, "R3 REM both neg");
    endtask

    task automatic t_div0;
        logic [W-1:0] res;
        int lat;
        run(2'b00, 32'h1234_5678, '0, res, lat);
        chk(res == '1, "R4 DIV by zero", res, '1);
        chk(lat == 2, "R6 special latency", W'(lat), 32'd2);
        run(2'b11, 32'hCAFE_0001, '0, res, lat);
        chk(res == 32'hCAFE_0001, "R4 REMU by zero", res, 32'hCAFE_0001);
        run(2'b10, 32'h8000_0003, '0, res, lat);
        chk(res == 32'h8000_0003, "R4 REM by zero", res, 32'h8000_0003);
    endtask

    task automatic t_ovf;
        logic [W-1:0] res;
        int lat;
        run(2'b00, 32'h8000_0000, 32'hFFFF_FFFF, res, lat);
        chk(res == 32'h8000_0000, "R5 DIV overflow", res, 32'h8000_0000);
        chk(lat == 2, "R6 overflow latency", W'(lat), 32'd2);
        run(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, res, lat);
        chk(res == '0, "R5 REM overflow", res, '0);
    endtask

    task automatic t_latency;
        logic [W-1:0] res;
        int lat;
        run(2'b01, 32'hFFFF_FFFF, 32'd1, res, lat);
        chk(lat == 34, "R6 longest latency", W'(lat), 32'd34);
        chk(res == 32'hFFFF_FFFF, "R1 divide by one", res, 32'hFFFF_FFFF);
    endtask

    task automatic t_busy_ignore;
        logic [W-1:0] res;
        int lat;
        @(negedge clk);
        op_i = 2'b01; dividend_i = 32'd1000; divisor_i = 32'd3; start_i = 1'b1;
        @(negedge clk);
        chk(busy_o, "R9 busy after start", W'(busy_o), 32'd1);
        op_i = 2'b11; dividend_i = 32'd77; divisor_i = 32'd10;
        @(negedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0; res = '0;
        for (int i = 0; i < 40; i++) begin
            if (done_o) begin
                res = result_o;
                start_i = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk(res == 32'd333, "R8 mid-run start ignored", res, 32'd333);
        @(negedge clk);
        start_i = 1'b0;
        chk(!busy_o, "R8 start in done cycle ignored", W'(busy_o), '0);
    endtask

    task automatic t_hold;
        logic [W-1:0] res;
        int lat;
        run(2'b01, 32'd90, 32'd9, res, lat);
        @(negedge clk);
        chk(!done_o, "R7 done single cycle", W'(done_o), '0);
        @(negedge clk);
        @(negedge clk);
        chk(result_o == 32'd10, "R7 result held", result_o, 32'd10);
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] a, b;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            a = seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            b = seed >> (seed[4:0]);
            check_op(2'(i), a, b, "R1 R2 R3 sweep");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_unsigned();
        t_signed();
        t_rem();
        t_div0();
        t_ovf();
        t_latency();
        t_busy_ignore();
        t_hold();
        t_sweep();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule